// File: doc/BRIEF.md
# 4:2:2 Video Output Pixel Sequencer

This block produces a byte-wide 4:2:2 video stream for an external NTSC/PAL encoder. It watches the encoder's horizontal and vertical sync lines and counts pixel columns from each horizontal sync. A four-phase chroma/luma state machine decides on every clock whether the outgoing byte is a Cb, Y, Cr or second-Y sample. Source samples arrive over a ready/valid handshake. Each horizontal sync reloads the phase with a value written by the host. Active video can therefore start on any column and still open on a Cb sample.

A small write-only host port sets the controls: the sync polarity, timing-reference insertion, chroma sign conversion, the width source, the active start column and the phase reload value. When insertion is on, a four-word timing reference brackets each line's active window. Outside active video, and outside those references, the output holds neutral blanking levels.

Top module: `vid422_pixel_seq`

## Requirements
- R1: The 2-bit phase register counts down by one each clock, wrapping. The encodings are Cb=2, Y=1, Cr=0, second Y=3, so the output order is Cb, Y, Cr, second Y, Cb. After reset the phase is 0.
- R2: Each sync input passes through two flops and is then compared with its previous value. A horizontal sync whose corrected value rises reloads the phase with the host value (register 1, bits 1:0) and sets the column count to 0. Column c of a line reaches `vid_data` on the (c+3)-th rising clock edge after the edge that first samples the sync. Before the first horizontal sync the line counts as idle.
- R3: When the reload value is (start column + 2) mod 4, the first active sample of every line is Cb, for any start column.
- R4: Control bit 0 (register 0) set means both sync inputs are active low. Cleared, they are active high.
- R5: `pix_ready` is high exactly on columns start ≤ c < start + 8·units, and only while the corrected vertical sync is inactive. The start column is register 2, bits 11:0.
- R6: The width in units of 8 pixels comes from the override width (register 3, bits 6:0) when the override mode (register 0, bits 4:3) is 01 or 10. Otherwise it comes from the normal width (register 3, bits 14:8).
- R7: A sample accepted with `pix_ready` and `pix_valid` both high appears on `vid_data` on the next clock with `vid_act` high. An active column without `pix_valid` outputs the blanking level with `vid_act` low.
- R8: When control bit 2 is set, the MSB of every output Cb and Cr sample is inverted. Luma samples always pass through unchanged.
- R9: Outside active video and outside timing references, the output is 0x80 on chroma phases and 0x10 on luma phases.
- R10: When control bit 1 is set, the words 0xFF, 0x00, 0x00 and a status word fill the four columns before the start column. The same four words fill the four columns from start + 8·units onward.
- R11: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H}. H is 0 before active video and 1 after it. V is the corrected vertical sync level. F toggles on each rise of the corrected vertical sync.
- R12: After reset, `vid_data` is 0x10 and `vid_act` and `pix_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register index |
| host_wdata | input | 16 | Host write data |
| hsync_in | input | 1 | Horizontal sync from the encoder |
| vsync_in | input | 1 | Vertical sync from the encoder |
| pix_valid | input | 1 | Source sample present |
| pix_data | input | 8 | Source sample byte |
| pix_ready | output | 1 | Block takes a sample this clock |
| vid_data | output | 8 | 4:2:2 output byte |
| vid_act | output | 1 | `vid_data` carries a source sample |

## Verification
Each of the four start columns 0 to 3 is run with its computed reload value and chroma inversion on. The first active byte then shows whether the interleave landed on Cb, and an off-by-one reload or a wrong count direction shows up as a luma sample. A second pattern uses active-low syncs, timing references, a start column of 6 and a source that skips cycles. It separates the override and normal width sources by the number of ready cycles per line, and blanking caused by underflow from data. A vertical sync interval checks that active video stops and that the V and F bits and their protection bits follow the field. A behavioural model predicts every output byte, `vid_act` and `pix_ready` on every clock.

// File: rtl/vsq_pkg.sv
// Shared types and helpers for the 4:2:2 pixel sequencer.
// Assumes byte-wide samples; phase codes count downward through the interleave.
package vsq_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] BLANK_CHROMA = 8'h80;
    localparam logic [BYTE_W-1:0] BLANK_LUMA   = 8'h10;

    // Interleave phases; the sequencer decrements, giving Cb, Y, Cr, Y2.
    typedef enum logic [1:0] {
        PH_CR = 2'd0,
        PH_Y  = 2'd1,
        PH_CB = 2'd2,
        PH_Y2 = 2'd3
    } phase_e;

    // Host control word, register 0 bits [4:0].
    typedef struct packed {
        logic [1:0] ovr_mode;
        logic       chroma_flip;
        logic       code_en;
        logic       sync_low;
    } ctrl_t;

    // Word of a four-word timing reference at position idx.
    function automatic logic [BYTE_W-1:0] ref_word(input logic [1:0] idx,
                                                   input logic f,
                                                   input logic v,
                                                   input logic h);
        case (idx)
            2'd0:    ref_word = 8'hFF;
            2'd3:    ref_word = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
            default: ref_word = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/vsq_host_regs.sv
// Host-written control registers.
// Assumes the write data width covers bit 14 (normal width field).
module vsq_host_regs #(
    parameter int HOST_AW = 2,
    parameter int HOST_DW = 16,
    parameter int COL_W   = 12,
    parameter int UNIT_W  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [HOST_AW-1:0]  addr,
    input  logic [HOST_DW-1:0]  wdata,
    output vsq_pkg::ctrl_t      ctrl,
    output logic [1:0]          phase_rst,
    output logic [COL_W-1:0]    start_col,
    output logic [UNIT_W-1:0]   ovr_units,
    output logic [UNIT_W-1:0]   norm_units
);
    localparam int NORM_LSB = 8;

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // Register file update on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            phase_rst  <= '0;
            start_col  <= '0;
            ovr_units  <= '0;
            norm_units <= '0;
        end else if (we) begin
            case (addr)
                HOST_AW'(0): ctrl      <= vsq_pkg::ctrl_t'(wdata[4:0]);
                HOST_AW'(1): phase_rst <= wdata[1:0];
                HOST_AW'(2): start_col <= wdata[COL_W-1:0];
                default: begin
                    ovr_units  <= wdata[UNIT_W-1:0];
                    norm_units <= wdata[NORM_LSB+UNIT_W-1:NORM_LSB];
                end
            endcase
        end
    end

endmodule

// File: rtl/vsq_sync_in.sv
// Polarity correction, multi-flop synchroniser and rise detector for one sync input.
// Assumes the raw input is asynchronous to clk; level is STAGES clocks late.
module vsq_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic level,
    output logic rise
);
    logic [STAGES:0] chain;

    // Shift the corrected input through the synchroniser and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], raw ^ invert};
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/vsq_line_timer.sv
// Column counter, interleave phase, field flag and window decode for one line.
// Assumes width_px is a multiple of 8; the column counter saturates (idle) at all ones.
module vsq_line_timer #(
    parameter int COL_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hload,
    input  logic               vlevel,
    input  logic               vrise,
    input  logic               code_en,
    input  logic [1:0]         phase_rst,
    input  logic [COL_W-1:0]   start_col,
    input  logic [COL_W:0]     width_px,
    output vsq_pkg::phase_e    phase,
    output logic               act,
    output logic               code_on,
    output logic               code_h,
    output logic [1:0]         code_idx,
    output logic               field
);
    localparam int EXT_W = COL_W + 2;
    localparam logic [EXT_W-1:0] REF_LEN = EXT_W'(4);

    logic [COL_W-1:0] col_q;
    logic             live;
    logic [EXT_W-1:0] col_e, start_e, end_e;
    logic             in_act, in_sav, in_eav;

    assign live = (col_q != '1);

    // Column count and phase: reload on horizontal sync, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '1;
            phase <= vsq_pkg::PH_CR;
        end else if (hload) begin
            col_q <= '0;
            phase <= vsq_pkg::phase_e'(phase_rst);
        end else begin
            phase <= vsq_pkg::phase_e'(phase - 2'd1);
            if (live) col_q <= col_q + 1'b1;
        end
    end

    // Field flag toggles on each vertical sync onset.
    always_ff @(posedge clk) begin
        if (!rst_n)     field <= 1'b0;
        else if (vrise) field <= ~field;
    end

    // Window decode against the programmed start and width.
    always_comb begin
        col_e    = EXT_W'(col_q);
        start_e  = EXT_W'(start_col);
        end_e    = start_e + EXT_W'(width_px);
        in_act   = (col_e >= start_e) && (col_e < end_e);
        in_sav   = (col_e + REF_LEN >= start_e) && (col_e < start_e);
        in_eav   = (col_e >= end_e) && (col_e < end_e + REF_LEN);
        act      = live & ~vlevel & in_act;
        code_on  = code_en & live & ~in_act & (in_sav | in_eav);
        code_h   = in_eav;
        code_idx = col_q[1:0] - start_col[1:0];
    end

endmodule

// File: rtl/vid422_pixel_seq.sv
// Top of the 4:2:2 pixel sequencer: syncs in, host controls, byte stream out.
// Assumes pix_data is presented with pix_valid and taken when pix_ready is high.
module vid422_pixel_seq #(
    parameter int HOST_AW   = 2,
    parameter int HOST_DW   = 16,
    parameter int COL_W     = 12,
    parameter int UNIT_W    = 7,
    parameter int SYNC_STG  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    input  logic               hsync_in,
    input  logic               vsync_in,
    input  logic               pix_valid,
    input  logic [7:0]         pix_data,
    output logic               pix_ready,
    output logic [7:0]         vid_data,
    output logic               vid_act
);
    import vsq_pkg::*;

    localparam int N_SYNC = 2;

    ctrl_t              cfg;
    logic [1:0]         phase_rst_w;
    logic [COL_W-1:0]   start_col_w;
    logic [UNIT_W-1:0]  ovr_units, norm_units, units_sel;
    logic [COL_W:0]     width_px;
    logic [N_SYNC-1:0]  sync_raw, sync_lvl, sync_rise;
    logic               unused_hlvl;
    phase_e             phase_w;
    logic               act_w, code_on, code_h, field_w, is_chroma;
    logic [1:0]         code_idx;
    logic [7:0]         byte_nxt;

    vsq_host_regs #(
        .HOST_AW(HOST_AW), .HOST_DW(HOST_DW), .COL_W(COL_W), .UNIT_W(UNIT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .ctrl(cfg), .phase_rst(phase_rst_w), .start_col(start_col_w),
        .ovr_units(ovr_units), .norm_units(norm_units)
    );

    assign sync_raw = {vsync_in, hsync_in};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        vsq_sync_in #(.STAGES(SYNC_STG)) u_sync (
            .clk(clk), .rst_n(rst_n), .raw(sync_raw[g]), .invert(cfg.sync_low),
            .level(sync_lvl[g]), .rise(sync_rise[g])
        );
    end

    assign unused_hlvl = sync_lvl[0];

    // Width source: override width only for override modes 01 and 10.
    always_comb begin
        units_sel = (cfg.ovr_mode == 2'b01 || cfg.ovr_mode == 2'b10) ? ovr_units : norm_units;
        width_px  = (COL_W+1)'({units_sel, 3'b000});
    end

    vsq_line_timer #(.COL_W(COL_W)) u_tim (
        .clk(clk), .rst_n(rst_n), .hload(sync_rise[0]), .vlevel(sync_lvl[1]),
        .vrise(sync_rise[1]), .code_en(cfg.code_en), .phase_rst(phase_rst_w),
        .start_col(start_col_w), .width_px(width_px), .phase(phase_w), .act(act_w),
        .code_on(code_on), .code_h(code_h), .code_idx(code_idx), .field(field_w)
    );

    assign pix_ready = act_w;
    assign is_chroma = (phase_w == PH_CB) || (phase_w == PH_CR);

    // Next output byte: sample, timing reference word or blanking level.
    always_comb begin
        byte_nxt = is_chroma ? BLANK_CHROMA : BLANK_LUMA;
        if (act_w) begin
            if (pix_valid) byte_nxt = pix_data ^ {cfg.chroma_flip & is_chroma, 7'b0};
        end else if (code_on) begin
            byte_nxt = ref_word(code_idx, field_w, sync_lvl[1], code_h);
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_data <= BLANK_LUMA;
            vid_act  <= 1'b0;
        end else begin
            vid_data <= byte_nxt;
            vid_act  <= act_w & pix_valid;
        end
    end

endmodule

// File: rtl/vsq_assert.sv
// Property checker for vid422_pixel_seq, attached by bind.
module vsq_assert #(
    parameter int COL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_ready,
    input logic             pix_valid,
    input logic [7:0]       pix_data,
    input logic [7:0]       vid_data,
    input logic             vid_act,
    input logic [1:0]       phase,
    input logic             hload,
    input logic [1:0]       phase_rst,
    input logic             code_en,
    input logic [COL_W-1:0] start_col
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !hload |=> phase == 2'($past(phase) - 2'd1));                        // R1
    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hload |=> phase == $past(phase_rst));                                // R2
    AST_ACT_FROM_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        vid_act |-> $past(pix_ready && pix_valid));                          // R7
    AST_LUMA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && pix_valid && phase[0]) |=> vid_data == $past(pix_data)); // R8
    AST_STATUS_BEFORE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_en && start_col != '0 && $rose(pix_ready)) |-> (vid_data[7] && !vid_data[4])); // R10
endmodule

bind vid422_pixel_seq vsq_assert #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .pix_valid(pix_valid),
    .pix_data(pix_data), .vid_data(vid_data), .vid_act(vid_act), .phase(phase_w),
    .hload(sync_rise[0]), .phase_rst(phase_rst_w), .code_en(cfg.code_en),
    .start_col(start_col_w)
);

// File: tb/sim_vid422_pixel_seq.sv
// Self-checking bench: behavioural per-clock model of the sequencer.
module sim_vid422_pixel_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        hs_raw = 1'b0, vs_raw = 1'b0;
    logic        pix_valid = 1'b1;
    logic [7:0]  pix_data = '0;
    logic        pix_ready, vid_act;
    logic [7:0]  vid_data;

    always #2 clk = ~clk;   // 250 MHz

    vid422_pixel_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .hsync_in(hs_raw), .vsync_in(vs_raw),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .vid_data(vid_data), .vid_act(vid_act)
    );

    int n_cmp = 0, n_bad = 0;
    // bench copy of the host configuration
    bit c_low = 0, c_bt = 0, c_flip = 0;
    int c_mode = 0, c_rst = 0, c_start = 0, c_ovr = 0, c_norm = 0;
    // model state
    bit hh[3], vh[3];
    bit mlive = 0, mf = 0;
    int mcol = 0, mk = 0;
    logic [7:0] exp_data = 8'h10;
    bit exp_act = 0, exp_ready = 0;
    string tag = "R12";
    logic [7:0] seq = 8'h00, first_byte = 8'h00;
    bit first_chk = 0, model_on = 0, valid_rand = 0;
    int n_first = 0, rdy_cnt = 0;
    logic [7:0] lfsr = 8'h5A;

    task automatic chk(input bit ok, input string req, input int got, input int want);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, want, $time);
        end
    endtask

    function automatic int units();
        return (c_mode == 1 || c_mode == 2) ? c_ovr : c_norm;
    endfunction

    function automatic logic [7:0] refw(input int idx, input bit f, input bit v, input bit h);
        if (idx == 0) return 8'hFF;
        if (idx == 3) return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return 8'h00;
    endfunction

    // Reference model: predicts the byte registered at this edge.
    always @(posedge clk) begin
        bit hc, vc, load, vr, vl, act, chroma;
        int mend;
        logic [7:0] blank;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin hh[i] = 0; vh[i] = 0; end
            mlive = 0; mf = 0; mcol = 0; mk = 0;
            exp_data = 8'h10; exp_act = 0; exp_ready = 0; tag = "R12"; first_chk = 0;
        end else begin
            model_on = 1;
            hc = hs_raw ^ c_low;
            vc = vs_raw ^ c_low;
            load = hh[1] && !hh[2];
            vr = vh[1] && !vh[2];
            vl = vh[1];
            mend = c_start + 8 * units();
            act = mlive && !vl && mcol >= c_start && mcol < mend;
            chroma = (mk == 0 || mk == 2);
            blank = chroma ? 8'h80 : 8'h10;
            exp_act = 0;
            first_chk = 0;
            if (act) begin
                if (pix_valid) begin
                    exp_data = pix_data ^ ((c_flip && chroma) ? 8'h80 : 8'h00);
                    exp_act = 1;
                    tag = "R7/R8";
                    if (mcol == c_start && c_flip) begin first_chk = 1; first_byte = pix_data; end
                    seq = seq + 8'd1;
                end else begin
                    exp_data = blank; tag = "R7/R9";
                end
            end else if (c_bt && mlive && mcol + 4 >= c_start && mcol < c_start) begin
                exp_data = refw(mcol + 4 - c_start, mf, vl, 0); tag = "R10/R11";
            end else if (c_bt && mlive && mcol >= mend && mcol < mend + 4) begin
                exp_data = refw(mcol - mend, mf, vl, 1); tag = "R10/R11";
            end else begin
                exp_data = blank; tag = "R1/R9";
            end
            if (load) begin
                mcol = 0; mlive = 1; mk = c_rst;
            end else begin
                mk = (mk + 3) % 4;
                if (mlive) begin
                    mcol++;
                    if (mcol == 4095) mlive = 0;
                end
            end
            if (vr) mf = !mf;
            hh[2] = hh[1]; hh[1] = hh[0]; hh[0] = hc;
            vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = vc;
            exp_ready = mlive && !vh[1] && mcol >= c_start && mcol < c_start + 8 * units();
        end
    end

    // Compare away from the edge, then drive the pixel source.
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk(vid_data == exp_data, tag, vid_data, exp_data);
            chk(vid_act == exp_act, "R7", vid_act, exp_act);
            chk(pix_ready == exp_ready, "R2/R5", pix_ready, exp_ready);
            if (first_chk) begin
                n_first++;
                chk(vid_data == (first_byte ^ 8'h80), "R3 first sample Cb", vid_data, first_byte ^ 8'h80);
            end
            if (pix_ready) rdy_cnt++;
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        pix_valid = valid_rand ? (lfsr[0] | lfsr[1]) : 1'b1;
        pix_data = seq;
    end

    task automatic hwr(input int a, input int d);
        host_we = 1'b1; host_addr = 2'(a); host_wdata = 16'(d);
        if (a == 0) begin hs_raw = d[0]; vs_raw = d[0]; end
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
        case (a)
            0: begin c_low = d[0]; c_bt = d[1]; c_flip = d[2]; c_mode = (d >> 3) & 3; end
            1: c_rst = d & 3;
            2: c_start = d & 12'hFFF;
            default: begin c_ovr = d & 8'h7F; c_norm = (d >> 8) & 8'h7F; end
        endcase
    endtask

    task automatic line(input int len);
        rdy_cnt = 0;
        hs_raw = !c_low;
        repeat (2) @(negedge clk);
        hs_raw = c_low;
        repeat (len - 2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(vid_data == 8'h10, "R12 reset data", vid_data, 8'h10);
        chk(vid_act == 1'b0, "R12 reset act", vid_act, 0);
        chk(pix_ready == 1'b0, "R12 reset ready", pix_ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Pattern A: high-true syncs, chroma flip, each start column 0..3
        hwr(3, 1 | (1 << 8));
        hwr(0, 4);
        for (int s = 0; s < 4; s++) begin
            hwr(2, s);
            hwr(1, (s + 2) % 4);
            line(40);
            chk(rdy_cnt == 8, "R5 ready window", rdy_cnt, 8);
            line(40);
        end
        chk(n_first == 8, "R3 lines starting on Cb", n_first, 8);
        hwr(0, 0);
        line(40);
        // Pattern B: low-true syncs, timing references, start 6, gappy source
        hwr(3, 1 | (2 << 8));
        hwr(2, 6);
        hwr(1, 0);
        hwr(0, 'h0F);
        valid_rand = 1;
        line(40); line(40);
        chk(rdy_cnt > 0, "R4 low-true sync lines run", rdy_cnt, 8);
        chk(rdy_cnt == 8, "R6 override mode 01", rdy_cnt, 8);
        hwr(0, 'h07);
        line(40); line(40);
        chk(rdy_cnt == 16, "R6 mode 00 normal width", rdy_cnt, 16);
        hwr(0, 'h17);
        line(40); line(40);
        chk(rdy_cnt == 8, "R6 override mode 10", rdy_cnt, 8);
        hwr(0, 'h1F);
        line(40); line(40);
        chk(rdy_cnt == 16, "R6 mode 11 normal width", rdy_cnt, 16);
        // Vertical interval
        vs_raw = !c_low;
        line(40); line(40);
        chk(rdy_cnt == 0, "R11 no active video in V", rdy_cnt, 0);
        vs_raw = c_low;
        line(40); line(40);
        chk(rdy_cnt == 16, "R11 active after V", rdy_cnt, 16);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule